// File: doc/BRIEF.md
# Byte-Wide Serial Data Buffer Handshake

This block joins a bit-serial modem datapath to an 8-bit data register that a host reads and writes. A single buffer-available flag coordinates the two sides. In receive direction the block collects one serial bit on each bit-rate strobe. After a full byte it places the byte in the register and raises the flag. A host read takes the byte and clears the flag. In transmit direction the block raises the flag to ask for a byte, and a host write clears it. The block then shifts the byte out one bit per strobe, and at each byte boundary it takes the register contents again.

A slow host does not stall the serial side. An unread receive byte is overwritten, a byte not refreshed in time is sent again, and both events set a sticky overrun status bit. Ending a transfer flushes data first. When receive energy is lost, the collected bits go to the register with zero padding. When request-to-send drops or setup is asserted, the byte already taken is shifted out before the block stops. The whole path works only while parallel data mode is enabled.

The control state machine has six states: `ST_IDLE`, `ST_RX_RUN`, `ST_RX_FLUSH`, `ST_TX_START`, `ST_TX_SHIFT` and `ST_HALT`. Its transitions are:
- `ST_IDLE` goes to `ST_RX_RUN` when the mode is enabled, the direction is receive and energy is present.
- `ST_IDLE` goes to `ST_TX_START` when the mode is enabled, the direction is transmit, request-to-send is high and setup is low. On this transition the request flag is raised.
- `ST_RX_RUN` goes to `ST_RX_FLUSH` on energy loss with bits pending, or to `ST_HALT` on energy loss with none pending.
- `ST_RX_FLUSH` goes to `ST_HALT` after writing the partial byte.
- `ST_TX_START` goes to `ST_TX_SHIFT` once the host has written. On a stop request it goes to `ST_HALT` instead.
- `ST_TX_SHIFT` goes to `ST_HALT` at the end of a byte when a stop request was seen at any point during that byte.
- `ST_HALT` goes to `ST_IDLE` once the ending condition of the current direction clears.
- Every state goes to `ST_IDLE` when the mode is disabled.

Top module: `sdb_bytebuf`

## Requirements
- R1: In both directions the block exchanges exactly one byte with the data register every BYTE_W bit-rate strobes.
- R2: In receive, `buf_avail` is 1 in the cycle after a byte is written to the register. A host read clears it when no new byte lands in the same cycle.
- R3: In transmit, entering `ST_TX_START` sets `buf_avail` as a request. A host write clears it. Shifting starts only after that write, and each byte boundary sets the request again.
- R4: If the host has not serviced the flag by the next byte boundary, receive overwrites the register with the new byte and transmit sends the register contents again.
- R5: Register bit 0 holds the first received serial bit and bit 7 the last. `tx_bit` sends bit 0 first and bit 7 last, and it holds steady between strobes.
- R6: When `energy_lost` is asserted in receive with k (1..BYTE_W-1) bits collected, the register receives those bits in bits 0..k-1 with the upper bits 0, and `buf_avail` is set. The block then halts with `running` low.
- R7: When `rts` goes low or `setup` goes high during `ST_TX_SHIFT`, the current byte is completed and then the block halts. In the halt state `tx_bit` is 1, `buf_avail` is 0 and `running` is 0.
- R8: While `pdm_en` is 0, host writes leave `host_rdata` unchanged and host reads leave `buf_avail` unchanged.
- R9: `overrun` is set by any receive overwrite of an unread byte or any transmit repeat. It then stays set until `ovr_clr` is pulsed, and it is 0 after reset.
- R10: After reset `buf_avail` is 0, `host_rdata` is 0, `tx_bit` is 1 and `running` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pdm_en | input | 1 | Parallel data mode enable |
| tx_mode | input | 1 | Direction: 1 transmit, 0 receive |
| bit_stb | input | 1 | One-cycle bit-rate strobe |
| rx_bit | input | 1 | Serial receive bit, sampled on the strobe |
| energy_lost | input | 1 | Receive energy below turn-off threshold |
| rts | input | 1 | Request to send (level) |
| setup | input | 1 | Setup request, ends transmit |
| host_wr | input | 1 | Host write strobe to the data register |
| host_wdata | input | BYTE_W | Host write data |
| host_rd | input | 1 | Host read strobe of the data register |
| ovr_clr | input | 1 | Write-one-to-clear pulse for the overrun bit |
| host_rdata | output | BYTE_W | Data register contents |
| buf_avail | output | 1 | Buffer-available flag |
| overrun | output | 1 | Sticky overrun status |
| tx_bit | output | 1 | Serial transmit bit (1 when not shifting) |
| running | output | 1 | Transfer in progress (not idle, not halted) |

## Verification
The bench builds the block with BYTE_W at its default of 8. With that value, byte patterns can be compared as hex constants, and a three-bit partial flush shows its zero padding directly in the upper five bits. An eight-strobe byte also leaves room to drop request-to-send partway through a byte and still observe the remaining bits being sent. The same width keeps the host-too-slow cases short: two back-to-back receive bytes, and a transmit byte that is repeated after one missed write.

// File: rtl/sdb_pkg.sv
`timescale 1ns/1ps
package sdb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RX_RUN   = 3'd1,
        ST_RX_FLUSH = 3'd2,
        ST_TX_START = 3'd3,
        ST_TX_SHIFT = 3'd4,
        ST_HALT     = 3'd5
    } sdb_state_e;
endpackage

// File: rtl/sdb_bitcnt.sv
`timescale 1ns/1ps
module sdb_bitcnt #(
    parameter int unsigned COUNT = 8,
    localparam int unsigned CW = (COUNT > 1) ? $clog2(COUNT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          at_last,
    output logic          is_zero
);
    assign at_last = (cnt == CW'(COUNT - 1));
    assign is_zero = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sdb_rx_asm.sv
`timescale 1ns/1ps
module sdb_rx_asm #(
    parameter int unsigned W = 8,
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          take,
    input  logic          bit_in,
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  merged
);
    logic [W-1:0] acc_q;

    for (genvar i = 0; i < W; i++) begin : g_slot
        logic hit;
        assign hit       = take && (idx == IW'(i));
        assign merged[i] = hit ? bit_in : acc_q[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[i] <= 1'b0;
            end else if (clr) begin
                acc_q[i] <= 1'b0;
            end else if (hit) begin
                acc_q[i] <= bit_in;
            end
        end
    end
endmodule

// File: rtl/sdb_tx_ser.sv
`timescale 1ns/1ps
module sdb_tx_ser #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         ser_bit
);
    logic [W-1:0] sh_q;

    assign ser_bit = sh_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_val;
        end else if (shift) begin
            sh_q <= {1'b0, sh_q[W-1:1]};
        end
    end
endmodule

// File: rtl/sdb_bytebuf.sv
`timescale 1ns/1ps
module sdb_bytebuf
    import sdb_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdm_en,
    input  logic              tx_mode,
    input  logic              bit_stb,
    input  logic              rx_bit,
    input  logic              energy_lost,
    input  logic              rts,
    input  logic              setup,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              ovr_clr,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              buf_avail,
    output logic              overrun,
    output logic              tx_bit,
    output logic              running
);
    localparam int unsigned CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    sdb_state_e state_q, state_d;

    logic [CW-1:0]     cnt;
    logic              cnt_last, cnt_zero, cnt_clr, cnt_inc;
    logic              stop_now, stop_pend_q, stop_eff, stop_latch;
    logic              host_wr_ok, host_rd_ok;
    logic              rx_take, rx_commit, asm_clr;
    logic              tx_first_req, tx_load, tx_shift, tx_halt;
    logic              rx_overwrite, tx_repeat;
    logic [BYTE_W-1:0] rx_byte, tx_src;
    logic              ser_bit;

    assign stop_now   = !rts || setup;
    assign stop_eff   = stop_now || stop_pend_q;
    assign host_wr_ok = pdm_en && tx_mode && host_wr;
    assign host_rd_ok = pdm_en && !tx_mode && host_rd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_mode) begin
                    if (!stop_now) state_d = ST_TX_START;
                end else begin
                    if (!energy_lost) state_d = ST_RX_RUN;
                end
            end
            ST_RX_RUN: begin
                if (energy_lost) state_d = cnt_zero ? ST_HALT : ST_RX_FLUSH;
            end
            ST_RX_FLUSH: state_d = ST_HALT;
            ST_TX_START: begin
                if (stop_now)        state_d = ST_HALT;
                else if (!buf_avail) state_d = ST_TX_SHIFT;
            end
            ST_TX_SHIFT: begin
                if (bit_stb && cnt_last && stop_eff) state_d = ST_HALT;
            end
            ST_HALT: begin
                if (tx_mode ? !stop_now : !energy_lost) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!pdm_en) state_d = ST_IDLE;
    end

    // outputs of the state machine
    always_comb begin
        rx_take      = 1'b0;
        rx_commit    = 1'b0;
        tx_load      = 1'b0;
        tx_shift     = 1'b0;
        stop_latch   = 1'b0;
        cnt_clr      = 1'b0;
        tx_first_req = 1'b0;
        tx_halt      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clr      = 1'b1;
                tx_first_req = pdm_en && (state_d == ST_TX_START);
            end
            ST_RX_RUN: begin
                rx_take   = pdm_en && bit_stb && !energy_lost;
                rx_commit = rx_take && cnt_last;
            end
            ST_RX_FLUSH: begin
                rx_commit = pdm_en;
                cnt_clr   = 1'b1;
            end
            ST_TX_START: begin
                tx_load = pdm_en && !buf_avail && !stop_now;
                cnt_clr = 1'b1;
                tx_halt = pdm_en && stop_now;
            end
            ST_TX_SHIFT: begin
                tx_shift   = pdm_en && bit_stb;
                stop_latch = stop_now;
                tx_load    = tx_shift && cnt_last && !stop_eff;
                tx_halt    = tx_shift && cnt_last && stop_eff;
            end
            ST_HALT: cnt_clr = 1'b1;
            default: cnt_clr = 1'b1;
        endcase
    end

    assign cnt_inc      = rx_take || tx_shift;
    assign asm_clr      = rx_commit || (state_q == ST_IDLE);
    assign tx_src       = host_wr_ok ? host_wdata : host_rdata;
    assign rx_overwrite = rx_commit && buf_avail && !host_rd_ok;
    assign tx_repeat    = tx_load && (state_q == ST_TX_SHIFT) && buf_avail && !host_wr_ok;

    sdb_bitcnt #(.COUNT(BYTE_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .cnt     (cnt),
        .at_last (cnt_last),
        .is_zero (cnt_zero)
    );

    sdb_rx_asm #(.W(BYTE_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (asm_clr),
        .take   (rx_take),
        .bit_in (rx_bit),
        .idx    (cnt),
        .merged (rx_byte)
    );

    sdb_tx_ser #(.W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .load_val (tx_src),
        .shift    (tx_shift),
        .ser_bit  (ser_bit)
    );

    // pending stop seen during the current transmit byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_pend_q <= 1'b0;
        end else if (state_q != ST_TX_SHIFT) begin
            stop_pend_q <= 1'b0;
        end else if (stop_latch) begin
            stop_pend_q <= 1'b1;
        end
    end

    // data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (rx_commit) begin
            host_rdata <= rx_byte;
        end else if (host_wr_ok) begin
            host_rdata <= host_wdata;
        end
    end

    // buffer-available flag: setting wins over clearing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_avail <= 1'b0;
        end else if (rx_commit || tx_load || tx_first_req) begin
            buf_avail <= 1'b1;
        end else if (tx_halt || host_rd_ok || host_wr_ok) begin
            buf_avail <= 1'b0;
        end
    end

    // sticky overrun status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (rx_overwrite || tx_repeat) begin
            overrun <= 1'b1;
        end else if (ovr_clr) begin
            overrun <= 1'b0;
        end
    end

    assign tx_bit  = (state_q == ST_TX_SHIFT) ? ser_bit : 1'b1;
    assign running = (state_q != ST_IDLE) && (state_q != ST_HALT);
endmodule

// File: rtl/sdb_bytebuf_chk.sv
`timescale 1ns/1ps
module sdb_bytebuf_chk
    import sdb_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pdm_en,
    input logic              tx_mode,
    input logic              host_wr,
    input logic              host_rd,
    input logic              ovr_clr,
    input logic              bit_stb,
    input logic [BYTE_W-1:0] host_rdata,
    input logic              buf_avail,
    input logic              overrun,
    input logic              tx_bit,
    input sdb_state_e        state_q,
    input logic              rx_commit,
    input logic              tx_load,
    input logic              tx_first_req
);
    AST_BYTE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_commit |=> buf_avail); // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pdm_en && !tx_mode && host_rd && !rx_commit) |=> !buf_avail); // R2
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pdm_en && tx_mode && host_wr && !tx_load && !tx_first_req) |=> !buf_avail); // R3
    AST_OFF_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdm_en && host_wr) |=> $stable(host_rdata)); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun); // R9
    AST_HALT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> tx_bit); // R7
    AST_TX_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (pdm_en && state_q == ST_TX_SHIFT && !bit_stb) |=> $stable(tx_bit)); // R5
endmodule

bind sdb_bytebuf sdb_bytebuf_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pdm_en       (pdm_en),
    .tx_mode      (tx_mode),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .ovr_clr      (ovr_clr),
    .bit_stb      (bit_stb),
    .host_rdata   (host_rdata),
    .buf_avail    (buf_avail),
    .overrun      (overrun),
    .tx_bit       (tx_bit),
    .state_q      (state_q),
    .rx_commit    (rx_commit),
    .tx_load      (tx_load),
    .tx_first_req (tx_first_req)
);

// File: tb/sim_sdb_bytebuf.sv
`timescale 1ns/1ps
module sim_sdb_bytebuf;
    localparam int unsigned BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pdm_en = 1'b0, tx_mode = 1'b0, bit_stb = 1'b0, rx_bit = 1'b0;
    logic          energy_lost = 1'b0, rts = 1'b0, setup = 1'b0;
    logic          host_wr = 1'b0, host_rd = 1'b0, ovr_clr = 1'b0;
    logic [BW-1:0] host_wdata = '0;
    logic [BW-1:0] host_rdata;
    logic          buf_avail, overrun, tx_bit, running;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sdb_bytebuf #(.BYTE_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .pdm_en(pdm_en), .tx_mode(tx_mode),
        .bit_stb(bit_stb), .rx_bit(rx_bit), .energy_lost(energy_lost),
        .rts(rts), .setup(setup), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .ovr_clr(ovr_clr), .host_rdata(host_rdata),
        .buf_avail(buf_avail), .overrun(overrun), .tx_bit(tx_bit), .running(running)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [BW-1:0] act, input logic [BW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rx_bits(input logic [BW-1:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            rx_bit = v[i];
            bit_stb = 1'b1;
            tick();
            bit_stb = 1'b0;
        end
    endtask

    task automatic tx_take(output logic [BW-1:0] got, input int drop_at);
        got = '0;
        for (int i = 0; i < BW; i++) begin
            got[i] = tx_bit;
            if (i == drop_at) rts = 1'b0;
            bit_stb = 1'b1;
            tick();
            bit_stb = 1'b0;
        end
    endtask

    task automatic host_read();
        host_rd = 1'b1; tick(); host_rd = 1'b0;
    endtask

    task automatic host_write(input logic [BW-1:0] d);
        host_wdata = d; host_wr = 1'b1; tick(); host_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk(BW'(buf_avail), 8'h00, "R10 flag after reset");
        chk(host_rdata, 8'h00, "R10 data after reset");
        chk(BW'(tx_bit), 8'h01, "R10 tx idle after reset");
        chk(BW'(running), 8'h00, "R10 running after reset");
        chk(BW'(overrun), 8'h00, "R9 overrun after reset");
    endtask

    task automatic t_rx_basic();
        pdm_en = 1'b1; tx_mode = 1'b0; energy_lost = 1'b0;
        tick();
        chk(BW'(running), 8'h01, "R1 rx running");
        rx_bits(8'hA5, BW - 1);
        chk(BW'(buf_avail), 8'h00, "R1 no flag before last bit");
        rx_bits(8'h01, 1);
        chk(BW'(buf_avail), 8'h01, "R2 flag after byte");
        chk(host_rdata, 8'hA5, "R5 rx bit order");
        host_read();
        chk(BW'(buf_avail), 8'h00, "R2 read clears flag");
    endtask

    task automatic t_rx_overrun();
        rx_bits(8'h11, BW);
        chk(host_rdata, 8'h11, "R1 first back-to-back byte");
        chk(BW'(overrun), 8'h00, "R9 no overrun on first byte");
        rx_bits(8'h7E, BW);
        chk(host_rdata, 8'h7E, "R4 unread byte overwritten");
        chk(BW'(overrun), 8'h01, "R9 overrun on overwrite");
        tick();
        chk(BW'(overrun), 8'h01, "R9 overrun sticky");
        ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
        chk(BW'(overrun), 8'h00, "R9 overrun cleared");
        host_read();
    endtask

    task automatic t_rx_flush();
        rx_bits(8'h03, 3);
        chk(BW'(buf_avail), 8'h00, "R6 no flag mid byte");
        energy_lost = 1'b1;
        tick();
        tick();
        chk(host_rdata, 8'h03, "R6 partial byte zero padded");
        chk(BW'(buf_avail), 8'h01, "R6 partial byte flagged");
        chk(BW'(running), 8'h00, "R6 receive halted");
        energy_lost = 1'b0; pdm_en = 1'b0;
        tick();
        host_read();
        chk(BW'(buf_avail), 8'h01, "R8 read ignored with mode off");
        pdm_en = 1'b1;
        host_read();
        chk(BW'(buf_avail), 8'h00, "R2 read clears with mode on");
        pdm_en = 1'b0;
        tick();
    endtask

    task automatic t_tx();
        logic [BW-1:0] got;
        tx_mode = 1'b1; rts = 1'b1; setup = 1'b0; pdm_en = 1'b1;
        tick();
        chk(BW'(buf_avail), 8'h01, "R3 request on start");
        tick();
        chk(BW'(tx_bit), 8'h01, "R3 no shifting before write");
        host_write(8'h3C);
        chk(BW'(buf_avail), 8'h00, "R3 write clears flag");
        tick();
        chk(BW'(buf_avail), 8'h01, "R3 next request after load");
        host_write(8'h81);
        tx_take(got, -1);
        chk(got, 8'h3C, "R5 tx bit order");
        chk(BW'(overrun), 8'h00, "R9 no overrun when serviced");
        chk(BW'(buf_avail), 8'h01, "R1 request at byte boundary");
        tx_take(got, -1);
        chk(got, 8'h81, "R1 second tx byte");
        chk(BW'(overrun), 8'h01, "R9 overrun on repeat");
        tx_take(got, 3);
        chk(got, 8'h81, "R4 repeated byte and R7 byte completed");
        chk(BW'(running), 8'h00, "R7 halted after stop");
        chk(BW'(tx_bit), 8'h01, "R7 line idle after stop");
        chk(BW'(buf_avail), 8'h00, "R7 flag cleared after stop");
    endtask

    task automatic t_mode_off();
        pdm_en = 1'b0;
        tick();
        host_write(8'hFF);
        chk(host_rdata, 8'h81, "R8 write ignored with mode off");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_rx_basic();
        t_rx_overrun();
        t_rx_flush();
        t_tx();
        t_mode_off();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule